// File: doc/BRIEF.md
# Phase-Frequency Detector with Counted Antibacklash Overlap

This block compares the output of a reference divider with the output of a feedback divider and produces charge-pump requests. Each divider output passes through a synchronizer on the fast system clock. A rising edge on the reference input sets the `up_o` request. A rising edge on the feedback input sets the `dn_o` request. The two requests stay set until both are high at the same time. After that, a small counter holds them together for a programmable number of system-clock cycles and then clears both of them in the same cycle.

The forced overlap means that every comparison produces a coincident pulse on both outputs, even when the phase error is zero, so the detector has no dead zone around lock. When the reference leads, `up_o` is wider than `dn_o` by the lead measured in cycles. When the feedback leads, `dn_o` is the wider one. A divider edge that is detected in the same cycle as the common clear sets its request again, so no comparison edge is ever lost.

All pins are plain control signals. The block has no streamed data interface, so it has no valid/ready handshake and no back-pressure.

Top module: `pfd_abl`

## Requirements
- R1: While `rst_n` is low, and after it is released with no divider edges, `up_o` and `dn_o` are both 0.
- R2: A rising edge on `ref_div` sets `up_o` to 1.
- R3: A rising edge on `fb_div` sets `dn_o` to 1.
- R4: Once both requests are high, they stay high together for exactly `ABL_CYCLES` cycles and then clear in the same cycle.
- R5: If the reference edge leads the feedback edge by d cycles, the `up_o` pulse lasts d+`ABL_CYCLES` cycles and the `dn_o` pulse lasts `ABL_CYCLES` cycles.
- R6: If the feedback edge leads the reference edge by d cycles, the `dn_o` pulse lasts d+`ABL_CYCLES` cycles and the `up_o` pulse lasts `ABL_CYCLES` cycles.
- R7: If the two edges are detected in the same cycle, both pulses last exactly `ABL_CYCLES` cycles.
- R8: A divider edge that is detected in the clearing cycle sets its request again, so that request is still 1 after the clear.
- R9: A divider input that is held high, or that falls, does not set its request. Only a low-to-high transition sets it.
- R10: A single set request stays high for as long as the other request is not set. It never clears on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the divider outputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_div | input | 1 | Reference divider output (asynchronous) |
| fb_div | input | 1 | Feedback divider output (asynchronous) |
| up_o | output | 1 | Pump-up request |
| dn_o | output | 1 | Pump-down request |

## Verification
Two functions can fall in the same cycle: the common clear at the end of the overlap window, and a fresh divider edge that would set a request. To provoke this, the bench drives both dividers high together. It then drops the reference and raises it again exactly `ABL_CYCLES` cycles later, so that the second detected reference edge lands on the clearing cycle. The bench judges the result at the pins: `up_o` must stay high after `dn_o` has cleared, and a following feedback edge must then end it with a normal overlap pulse of `ABL_CYCLES` cycles.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned PFD_CH = 2;
  localparam int unsigned CH_REF = 0;
  localparam int unsigned CH_FB  = 1;

  typedef struct packed {
    logic up;
    logic dn;
  } pfd_req_t;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pfd_flag.sv
module pfd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  // a set in the clearing cycle wins, so the edge survives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/pfd_abl_timer.sv
module pfd_abl_timer #(
  parameter int unsigned ABL_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic both,
  output logic clr
);
  localparam int unsigned CW = (ABL_CYCLES > 1) ? $clog2(ABL_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(ABL_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign clr = both && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= LOAD;
    else if (!both || clr)  cnt_q <= LOAD;
    else                    cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/pfd_abl.sv
module pfd_abl #(
  parameter int unsigned ABL_CYCLES  = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_div,
  input  logic fb_div,
  output logic up_o,
  output logic dn_o
);
  import pfd_pkg::*;

  logic [PFD_CH-1:0] div_in;
  logic [PFD_CH-1:0] rise;
  logic [PFD_CH-1:0] flag;
  logic              clr;
  logic              ref_rise;
  logic              fb_rise;
  pfd_req_t          req;

  assign div_in[CH_REF] = ref_div;
  assign div_in[CH_FB]  = fb_div;

  for (genvar g = 0; g < PFD_CH; g++) begin : g_ch
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(div_in[g]), .rise(rise[g])
    );
    pfd_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(rise[g]), .clr(clr), .q(flag[g])
    );
  end

  pfd_abl_timer #(.ABL_CYCLES(ABL_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .both(&flag), .clr(clr)
  );

  assign ref_rise = rise[CH_REF];
  assign fb_rise  = rise[CH_FB];
  assign req.up   = flag[CH_REF];
  assign req.dn   = flag[CH_FB];
  assign up_o     = req.up;
  assign dn_o     = req.dn;
endmodule

// File: rtl/pfd_abl_chk.sv
module pfd_abl_chk #(
  parameter int unsigned ABL_CYCLES = 3
) (
  input logic clk,
  input logic rst_n,
  input logic up,
  input logic dn,
  input logic ref_rise,
  input logic fb_rise,
  input logic clr
);
  localparam int unsigned OW = $clog2(ABL_CYCLES + 1) + 1;
  logic [OW-1:0] ov_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ov_q <= '0;
    else if (up && dn && !clr)  ov_q <= ov_q + 1'b1;
    else                        ov_q <= '0;
  end

  p_rise_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up) |-> $past(ref_rise));
  p_rise_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn) |-> $past(fb_rise));
  p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (ov_q == OW'(ABL_CYCLES - 1)));
  p_no_long_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up && dn) |-> (ov_q < OW'(ABL_CYCLES)));
  p_keep_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ref_rise) |=> up);
  p_keep_dn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && fb_rise) |=> dn);
  p_up_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up) |-> $past(dn));
  p_dn_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dn) |-> $past(up));
endmodule

bind pfd_abl pfd_abl_chk #(.ABL_CYCLES(ABL_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .up(up_o), .dn(dn_o),
  .ref_rise(ref_rise), .fb_rise(fb_rise), .clr(clr)
);

// File: tb/test_pfd_abl.sv
module test_pfd_abl;
  localparam int ABL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_div = 1'b0;
  logic fb_div = 1'b0;
  logic up_o, dn_o;

  int n_chk = 0, n_err = 0, cyc = 0;
  int cur_up = 0, cur_dn = 0, last_up = 0, last_dn = 0;

  always #2.5 clk = ~clk;

  pfd_abl #(.ABL_CYCLES(ABL)) i_pfd_abl (
    .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .fb_div(fb_div),
    .up_o(up_o), .dn_o(dn_o)
  );

  always @(negedge clk) begin
    cyc++;
    if (up_o) cur_up++; else if (cur_up > 0) begin last_up = cur_up; cur_up = 0; end
    if (dn_o) cur_dn++; else if (cur_dn > 0) begin last_dn = cur_dn; cur_dn = 0; end
    if (cyc > 100000) begin
      n_err++;
      $display("FAIL watchdog: actual cycles=%0d expected below 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    ref_div = 1'b0; fb_div = 1'b0;
    wait_cyc(8);
    last_up = 0; last_dn = 0;
  endtask

  // R5 / R6 / R7: measured pulse widths for a given lead
  task automatic t_pair(input bit ref_first, input int d, input string req);
    idle();
    if (ref_first) begin ref_div = 1'b1; wait_cyc(d); fb_div = 1'b1; end
    else begin fb_div = 1'b1; wait_cyc(d); ref_div = 1'b1; end
    wait_cyc(d + ABL + 10);
    check({req, " up width"}, last_up, ref_first ? d + ABL : ABL + (d == 0 ? 0 : 0) + (ref_first ? 0 : 0));
    check({req, " dn width"}, last_dn, ref_first ? ABL : d + ABL);
    idle();
  endtask

  task automatic t_reset();
    check("R1 up in reset", int'(up_o), 0);
    check("R1 dn in reset", int'(dn_o), 0);
    rst_n = 1'b1;
    wait_cyc(6);
    check("R1 up after release", int'(up_o), 0);
    check("R1 dn after release", int'(dn_o), 0);
  endtask

  // R2, R10, R9, R4
  task automatic t_single_ref();
    idle();
    ref_div = 1'b1;
    wait_cyc(6);
    check("R2 up set", int'(up_o), 1);
    check("R2 dn idle", int'(dn_o), 0);
    wait_cyc(20);
    check("R10 up held", int'(up_o), 1);
    fb_div = 1'b1;
    wait_cyc(ABL + 8);
    check("R4 dn overlap width", last_dn, ABL);
    check("R9 up not reset by held ref", int'(up_o), 0);
    ref_div = 1'b0;
    wait_cyc(6);
    check("R9 falling ref ignored", int'(up_o), 0);
    idle();
  endtask

  task automatic t_single_fb();
    idle();
    fb_div = 1'b1;
    wait_cyc(6);
    check("R3 dn set", int'(dn_o), 1);
    check("R3 up idle", int'(up_o), 0);
    wait_cyc(15);
    check("R10 dn held", int'(dn_o), 1);
    ref_div = 1'b1;
    wait_cyc(ABL + 8);
    check("R4 up overlap width", last_up, ABL);
    idle();
  endtask

  // R8: second ref edge detected in the clearing cycle
  task automatic t_collide();
    idle();
    ref_div = 1'b1; fb_div = 1'b1;
    wait_cyc(1);
    ref_div = 1'b0; fb_div = 1'b0;
    wait_cyc(ABL - 1);
    ref_div = 1'b1;
    wait_cyc(10);
    check("R8 up survives clear", int'(up_o), 1);
    check("R8 dn cleared", int'(dn_o), 0);
    last_dn = 0;
    fb_div = 1'b1;
    wait_cyc(ABL + 8);
    check("R8 follow-up dn width", last_dn, ABL);
    check("R8 up cleared after follow-up", int'(up_o), 0);
    idle();
  endtask

  initial begin
    wait_cyc(3);
    t_reset();
    t_single_ref();
    t_single_fb();
    t_pair(1'b1, 2, "R5 lead2");
    t_pair(1'b1, 5, "R5 lead5");
    t_pair(1'b0, 4, "R6 lag4");
    t_pair(1'b0, 1, "R6 lag1");
    t_pair(1'b1, 0, "R7 zero");
    t_pair(1'b0, 0, "R7 zero again");
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule